// File: doc/BRIEF.md
# Bit-Serial Integer ALU

This block is a small-area arithmetic and logic unit for a 32-bit integer core. It does not use a parallel datapath. The surrounding datapath loads two operand shift registers and a next-PC register in parallel, then starts an operation. The unit then works through the operands one bit per clock, least-significant bit first, using a single one-bit adder/logic slice. A one-bit carry register links each bit to the next. Each result bit is shifted back into the top of a destination register. That destination is either the first operand register or the next-PC register, chosen by a select input sampled at start.

The second operand register rotates instead of shifting, so it holds its original value again once the operation completes. When the result goes to the next-PC register, the first operand register also rotates and is kept. A bit counter keeps the unit busy for exactly one pass over the word. A one-cycle done pulse marks completion, and at that point the carry and signed-overflow flags are updated. Set-less-than forms its answer from the final sign and overflow and writes a 0 or 1 word. Multiply, divide and floating point are not handled.

Top module: `serial_alu`

## Requirements
- R1: After reset, the three data registers read zero and `busy_o`, `done_o`, `carry_o` and `ovf_o` are low.
- R2: While idle, a high `load_a_i`, `load_b_i` or `load_npc_i` at a clock edge copies the matching parallel input into that register. While busy, these loads are ignored and do not change the result.
- R3: A high `start_i` sampled while idle raises `busy_o` from the next cycle, and it stays high for exactly WIDTH cycles. A `start_i` sampled while busy is ignored.
- R4: `done_o` is high for exactly one cycle. That cycle is the first one after the last bit is processed, and in it `busy_o` is already low.
- R5: Operation code 0 adds and code 1 subtracts (A minus B). Both work modulo 2^WIDTH.
- R6: Codes 2, 3, 4 and 5 give the bitwise AND, OR, XOR and NOR of A and B.
- R7: Code 6 (set-less-than) writes 1 when A is below B as signed numbers, and 0 otherwise. All other result bits are zero.
- R8: With `dest_npc_i` low at start, the result replaces A and the next-PC register is unchanged. With it high, the result replaces the next-PC register and A is unchanged. B holds its loaded value after every operation.
- R9: At completion, `carry_o` is the carry out of the top bit for add and subtract (for subtract, 1 means no borrow). It is 0 after a logic operation, and it holds while idle.
- R10: At completion, `ovf_o` flags signed overflow of add, subtract and set-less-than. It is 0 after a logic operation, and it holds while idle.
- R11: Code 7 behaves exactly as add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_a_i | input | 1 | Parallel load of operand A while idle |
| a_i | input | WIDTH | Value for operand A |
| load_b_i | input | 1 | Parallel load of operand B while idle |
| b_i | input | WIDTH | Value for operand B |
| load_npc_i | input | 1 | Parallel load of next-PC register while idle |
| npc_i | input | WIDTH | Value for next-PC register |
| op_i | input | 3 | Operation code, sampled at start |
| start_i | input | 1 | Begin an operation (ignored while busy) |
| dest_npc_i | input | 1 | Result destination, sampled at start: 0 = A, 1 = next-PC |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Carry out of the top bit from the last operation |
| ovf_o | output | 1 | Signed overflow from the last operation |
| a_o | output | WIDTH | Operand A register |
| b_o | output | WIDTH | Operand B register |
| npc_o | output | WIDTH | Next-PC register |

## Verification
The hardest case to reach is a set-less-than whose subtraction overflows. Here the sign bit alone gives the wrong answer, and only the top-bit carry into the final cycle corrects it. The stimulus covers this with operand pairs of opposite sign at the extremes of the range, such as the most negative value against the most positive.

A second hard case is input that arrives while the unit is busy. The bench issues a second start and parallel loads with unrelated values part way through an operation. It then checks that neither the result nor the done timing moved. A cycle model of busy and done is compared on every clock over all of these runs.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_NOR = 3'd5,
        OP_SLT = 3'd6,
        OP_RSV = 3'd7
    } alu_op_e;

    function automatic logic op_inverts_b(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SLT);
    endfunction

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT) || (op == OP_RSV);
    endfunction

endpackage

// File: rtl/serial_alu_slice.sv
module serial_alu_slice
    import serial_alu_pkg::*;
(
    input  alu_op_e op_i,
    input  logic    a_bit_i,
    input  logic    b_bit_i,
    input  logic    c_in_i,
    output logic    res_bit_o,
    output logic    sum_bit_o,
    output logic    c_out_o
);

    logic b_eff;

    always_comb begin
        b_eff     = b_bit_i ^ op_inverts_b(op_i);
        sum_bit_o = a_bit_i ^ b_eff ^ c_in_i;
        c_out_o   = (a_bit_i & b_eff) | (a_bit_i & c_in_i) | (b_eff & c_in_i);
        unique case (op_i)
            OP_AND:  res_bit_o = a_bit_i & b_bit_i;
            OP_OR:   res_bit_o = a_bit_i | b_bit_i;
            OP_XOR:  res_bit_o = a_bit_i ^ b_bit_i;
            OP_NOR:  res_bit_o = ~(a_bit_i | b_bit_i);
            default: res_bit_o = sum_bit_o;
        endcase
    end

endmodule

// File: rtl/serial_alu_seq.sv
module serial_alu_seq #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o,
    output logic go_o,
    output logic done_o
);

    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        go_o       = start_i && !seq_q.busy;
        last_o     = seq_q.busy && (seq_q.cnt == LAST_IDX);
        if (go_o) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = '0;
        end else if (seq_q.busy) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
            if (last_o) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = seq_q.busy;
    assign done_o = seq_q.done;

endmodule

// File: rtl/serial_alu.sv
module serial_alu
    import serial_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_a_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic             load_b_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             load_npc_i,
    input  logic [WIDTH-1:0] npc_i,
    input  logic [2:0]       op_i,
    input  logic             start_i,
    input  logic             dest_npc_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic [WIDTH-1:0] a_o,
    output logic [WIDTH-1:0] b_o,
    output logic [WIDTH-1:0] npc_o
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] npc;
        logic             carry;
        alu_op_e          op;
        logic             to_npc;
        logic             cflag;
        logic             vflag;
    } dp_t;

    dp_t dp_d, dp_q;

    logic busy, last, go;
    logic res_bit, sum_bit, c_out;
    logic ovf_now, slt_bit, wr_bit;
    logic [WIDTH-1:0] slt_word;

    serial_alu_seq #(.WIDTH(WIDTH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .busy_o  (busy),
        .last_o  (last),
        .go_o    (go),
        .done_o  (done_o)
    );

    serial_alu_slice u_slice (
        .op_i      (dp_q.op),
        .a_bit_i   (dp_q.a[0]),
        .b_bit_i   (dp_q.b[0]),
        .c_in_i    (dp_q.carry),
        .res_bit_o (res_bit),
        .sum_bit_o (sum_bit),
        .c_out_o   (c_out)
    );

    always_comb begin
        dp_d     = dp_q;
        ovf_now  = dp_q.carry ^ c_out;
        slt_bit  = sum_bit ^ ovf_now;
        slt_word = {{TOP{1'b0}}, slt_bit};
        wr_bit   = (dp_q.op == OP_SLT) ? 1'b0 : res_bit;

        if (!busy) begin
            if (load_a_i)   dp_d.a   = a_i;
            if (load_b_i)   dp_d.b   = b_i;
            if (load_npc_i) dp_d.npc = npc_i;
            if (go) begin
                dp_d.op     = alu_op_e'(op_i);
                dp_d.to_npc = dest_npc_i;
                dp_d.carry  = op_inverts_b(alu_op_e'(op_i));
            end
        end else begin
            dp_d.b     = {dp_q.b[0], dp_q.b[TOP:1]};
            dp_d.carry = c_out;
            if (dp_q.to_npc) begin
                dp_d.npc = {wr_bit, dp_q.npc[TOP:1]};
                dp_d.a   = {dp_q.a[0], dp_q.a[TOP:1]};
            end else begin
                dp_d.a   = {wr_bit, dp_q.a[TOP:1]};
            end
            if (last) begin
                dp_d.cflag = op_is_arith(dp_q.op) & c_out;
                dp_d.vflag = op_is_arith(dp_q.op) & ovf_now;
                if (dp_q.op == OP_SLT) begin
                    if (dp_q.to_npc) dp_d.npc = slt_word;
                    else             dp_d.a   = slt_word;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign busy_o  = busy;
    assign carry_o = dp_q.cflag;
    assign ovf_o   = dp_q.vflag;
    assign a_o     = dp_q.a;
    assign b_o     = dp_q.b;
    assign npc_o   = dp_q.npc;

endmodule

// File: rtl/serial_alu_chk.sv
module serial_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             load_b_i,
    input logic             load_npc_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             carry_o,
    input logic             ovf_o,
    input logic [WIDTH-1:0] b_o,
    input logic [WIDTH-1:0] npc_o
);

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!busy_o && $past(busy_o)));

    p_b_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_b_i) |=> $stable(b_o));

    p_npc_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_npc_i) |=> $stable(npc_o));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(carry_o) && $stable(ovf_o)));

endmodule

bind serial_alu serial_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .load_b_i   (load_b_i),
    .load_npc_i (load_npc_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .carry_o    (carry_o),
    .ovf_o      (ovf_o),
    .b_o        (b_o),
    .npc_o      (npc_o)
);

// File: tb/serial_alu_test.sv
`timescale 1ns/1ps
module serial_alu_test;

    localparam int W = 32;
    localparam real HALF = 2.5;

    logic clk = 0;
    logic rst_n = 0;
    logic load_a = 0, load_b = 0, load_npc = 0;
    logic [W-1:0] a_in = '0, b_in = '0, npc_in = '0;
    logic [2:0] op = '0;
    logic start = 0, dest = 0;
    logic busy, done, carry, ovf;
    logic [W-1:0] a_out, b_out, npc_out;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] ea = '0, eb = '0, enpc = '0;
    logic ec = 0, ev = 0;
    int left = 0;
    logic edone = 0;

    always #(HALF) clk = ~clk;

    serial_alu #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .load_a_i(load_a), .a_i(a_in),
        .load_b_i(load_b), .b_i(b_in),
        .load_npc_i(load_npc), .npc_i(npc_in),
        .op_i(op), .start_i(start), .dest_npc_i(dest),
        .busy_o(busy), .done_o(done), .carry_o(carry), .ovf_o(ovf),
        .a_o(a_out), .b_o(b_out), .npc_o(npc_out)
    );

    task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle model of busy / done
    always @(posedge clk) begin
        if (!rst_n) begin
            left = 0; edone = 0;
        end else begin
            edone = (left == 1);
            if (left > 0) left = left - 1;
            else if (start) left = W;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (left > 0), "R3 busy", W'(busy), W'(left > 0));
            chk(done == edone, "R4 done", W'(done), W'(edone));
        end
    end

    function automatic logic [W:0] calc(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] s;
        case (o)
            3'd0, 3'd7: s = {1'b0, x} + {1'b0, y};
            3'd1: s = {1'b0, x} + {1'b0, ~y} + 1;
            3'd2: s = {1'b0, x & y};
            3'd3: s = {1'b0, x | y};
            3'd4: s = {1'b0, x ^ y};
            3'd5: s = {1'b0, ~(x | y)};
            default: s = {1'b0, W'($signed(x) < $signed(y))};
        endcase
        return s;
    endfunction

    task automatic do_load(input logic [W-1:0] x, input logic [W-1:0] y, input logic [W-1:0] p);
        @(negedge clk);
        load_a = 1; load_b = 1; load_npc = 1; a_in = x; b_in = y; npc_in = p;
        @(negedge clk);
        load_a = 0; load_b = 0; load_npc = 0;
        ea = x; eb = y; enpc = p;
        chk(a_out == ea, "R2 load a", a_out, ea);
        chk(b_out == eb, "R2 load b", b_out, eb);
        chk(npc_out == enpc, "R2 load npc", npc_out, enpc);
    endtask

    task automatic run(input logic [2:0] o, input logic d, input logic disturb);
        logic [W:0] s;
        logic [W-1:0] diff;
        int n;
        s = calc(o, ea, eb);
        diff = ea - eb;
        if (o == 3'd0 || o == 3'd7) begin
            ec = s[W];
            ev = (ea[W-1] == eb[W-1]) && (s[W-1] != ea[W-1]);
        end else if (o == 3'd1 || o == 3'd6) begin
            ec = calc(3'd1, ea, eb) >> W;
            ev = (ea[W-1] != eb[W-1]) && (diff[W-1] != ea[W-1]);
        end else begin
            ec = 0; ev = 0;
        end
        @(negedge clk);
        op = o; dest = d; start = 1;
        @(negedge clk);
        start = 0;
        n = 0;
        while (!done && n < 3 * W) begin
            if (disturb && n == 5) begin
                start = 1; op = 3'd2; dest = ~d;
                load_a = 1; load_b = 1; load_npc = 1;
                a_in = 32'h1234_5678; b_in = 32'h0F0F_0F0F; npc_in = 32'hDEAD_BEEF;
            end else begin
                start = 0; load_a = 0; load_b = 0; load_npc = 0;
            end
            @(negedge clk);
            n++;
        end
        start = 0; load_a = 0; load_b = 0; load_npc = 0;
        if (d) enpc = s[W-1:0];
        else ea = s[W-1:0];
        chk(done == 1'b1, "R4 done seen", W'(done), 1);
        chk(a_out == ea, d ? "R8 a kept" : "R5 R6 R7 R11 result in a", a_out, ea);
        chk(npc_out == enpc, d ? "R5 R6 R7 R11 result in npc" : "R8 npc kept", npc_out, enpc);
        chk(b_out == eb, "R8 b kept", b_out, eb);
        chk(carry == ec, "R9 carry", W'(carry), W'(ec));
        chk(ovf == ev, "R10 overflow", W'(ovf), W'(ev));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(a_out == 0 && b_out == 0 && npc_out == 0, "R1 regs zero", a_out | b_out | npc_out, 0);
        chk(!busy && !done && !carry && !ovf, "R1 flags low", W'({busy, done, carry, ovf}), 0);

        do_load(32'd5, 32'd7, 32'h100);          run(3'd0, 0, 0); // R5 add
        do_load(32'hFFFF_FFFF, 32'd1, 32'h4);    run(3'd0, 0, 0); // R9 carry
        do_load(32'h7FFF_FFFF, 32'd1, 32'h8);    run(3'd0, 1, 0); // R10 overflow
        do_load(32'd3, 32'd5, 32'h40);           run(3'd1, 1, 0); // R5 sub borrow
        do_load(32'h8000_0000, 32'd1, 32'h0);    run(3'd1, 0, 0); // R10 sub overflow
        do_load(32'hF0F0_3C3C, 32'hFF00_0FF0, 0); run(3'd2, 0, 0); // R6 and
        do_load(32'hF0F0_3C3C, 32'hFF00_0FF0, 0); run(3'd3, 1, 0); // R6 or
        do_load(32'hF0F0_3C3C, 32'hFF00_0FF0, 0); run(3'd4, 0, 0); // R6 xor
        do_load(32'hF0F0_3C3C, 32'hFF00_0FF0, 0); run(3'd5, 1, 0); // R6 nor
        do_load(32'hFFFF_FFFF, 32'd1, 32'h77);   run(3'd6, 0, 0); // R7 slt true
        do_load(32'd5, 32'd3, 32'h77);           run(3'd6, 1, 0); // R7 slt false
        do_load(32'h8000_0000, 32'h7FFF_FFFF, 0); run(3'd6, 0, 0); // R7 slt overflow
        do_load(32'h7FFF_FFFF, 32'h8000_0000, 0); run(3'd6, 1, 0); // R7 slt overflow
        do_load(32'h1234_0000, 32'h0000_5678, 0); run(3'd7, 0, 0); // R11 code 7
        do_load(32'hAAAA_0001, 32'h0000_0003, 32'h55); run(3'd0, 0, 1); // R2 R3 disturb
        do_load(32'hAAAA_0001, 32'h0000_0003, 32'h55); run(3'd1, 1, 1); // R2 R3 disturb
        for (int i = 0; i < 24; i++) begin
            do_load($urandom, $urandom, $urandom);
            run(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 0);
        end
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(HALF * 2 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule